// File: doc/BRIEF.md
# Condition-Register Compare Unit

This unit performs the compare step of an integer pipeline. It takes two 64-bit operands, or one operand and a 16-bit immediate, and builds a 4-bit result nibble. The nibble reports less-than, greater-than and equal, plus a copy of the sticky overflow flag. The unit then writes that nibble into one of eight 4-bit fields of a 32-bit condition register and leaves the other fields as they were. A separate byte-search operation reports whether the low byte of operand A appears anywhere in the eight bytes of operand B.

A length bit chooses the comparison width. When the bit is 1, all 64 bits are compared. When it is 0, only the low 32 bits of each operand are used, widened by sign extension for a signed compare and by zero extension for an unsigned one. Register reading and instruction decode are outside the unit: the caller supplies the operands, the current condition register and the field index. The updated register appears on the output one clock later.

Top module: `crcmp_unit`

## Requirements
- R1: While reset is asserted, `cr_out` is 0.
- R2: `cr_out` is registered. It shows the result of the inputs sampled at the previous rising clock edge.
- R3: `op_sel` encoding: 0 is a signed compare, 1 an unsigned compare, 2 an unsigned compare against the immediate, 3 the byte search. For the three compares, nibble bit 3 is less-than, bit 2 is greater-than and bit 1 is equal, and exactly one of these three bits is set. Nibble bit 0 equals `so_in`.
- R4: With `len_full`=0, only bits 31:0 of each operand are compared. They are sign-extended for op 0 and zero-extended for ops 1 and 2. Example: signed compare of 0xffffffffaaaaaaaa with 0x00000000aaaaaaaa gives equal (nibble 0x2 when `so_in`=0).
- R5: With `len_full`=1, all 64 bits are compared. In the example above the result is less-than (0x8), and greater-than (0x4) when the operands are swapped.
- R6: Op 2 zero-extends `imm` and compares it with operand A. Operand B has no effect on the result.
- R7: Op 3 gives nibble 0x4 when `opnd_a[7:0]` equals any byte of `opnd_b`, and 0x0 otherwise. Bits 63:8 of operand A have no effect.
- R8: Op 3 clears nibble bit 0 whatever the value of `so_in`.
- R9: Field index f selects bits (31-4f) down to (28-4f), so field 0 is bits 31:28 and field 7 is bits 3:0. All other bits of `cr_out` equal `cr_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_sel | input | 2 | Operation select (see R3) |
| len_full | input | 1 | 1: 64-bit compare, 0: 32-bit compare |
| opnd_a | input | 64 | First operand; its low byte is the search key for op 3 |
| opnd_b | input | 64 | Second operand; the searched word for op 3 |
| imm | input | 16 | Unsigned immediate for op 2 |
| field_idx | input | 3 | Index of the condition-register field to write |
| so_in | input | 1 | Summary-overflow flag |
| cr_in | input | 32 | Current condition register |
| cr_out | output | 32 | Updated condition register |

## Verification
On every clock, the assertions check that the seven unselected fields pass through unchanged and that a compare sets exactly one of less-than, greater-than and equal. They also check that bit 0 of a compare nibble follows the overflow flag and that the byte search leaves only the greater-than position free to be set. Whether that single bit is the correct one can only be shown by the bench scenarios. These include the 32-bit versus 64-bit extension cases, the 0x7fffffff versus 0x80000000 boundary under signed and unsigned views, the immediate path with a noisy operand B, byte hits and misses, and all eight field positions.

// File: rtl/crcmp_pkg.sv
package crcmp_pkg;
   typedef enum logic [1:0] {
      OP_SCMP  = 2'd0,
      OP_UCMP  = 2'd1,
      OP_UCMPI = 2'd2,
      OP_BYTEQ = 2'd3
   } cmp_op_e;

   localparam int NIB_W = 4;
   localparam int NIB_LT = 3;
   localparam int NIB_GT = 2;
   localparam int NIB_EQ = 1;
   localparam int NIB_SO = 0;
endpackage

// File: rtl/cmp_magnitude.sv
module cmp_magnitude #(
   parameter int DATA_W = 64,
   parameter int HALF_W = 32,
   parameter int IMM_W  = 16,
   parameter bit BY_SUBTRACT = 1'b0
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic [IMM_W-1:0]  imm,
   input  logic              is_signed,
   input  logic              use_imm,
   input  logic              len_full,
   output logic              lt,
   output logic              gt,
   output logic              eq
);
   localparam int EXT_W = DATA_W - HALF_W;
   localparam int PAD_W = DATA_W - IMM_W;

   logic [DATA_W-1:0] b_sel;
   logic [DATA_W-1:0] ext_a, ext_b;
   logic [DATA_W:0]   wide_a, wide_b;

   always_comb begin
      b_sel = use_imm ? {{PAD_W{1'b0}}, imm} : b;
      if (len_full) begin
         ext_a = a;
         ext_b = b_sel;
      end else begin
         ext_a = {{EXT_W{is_signed & a[HALF_W-1]}}, a[HALF_W-1:0]};
         ext_b = {{EXT_W{is_signed & b_sel[HALF_W-1]}}, b_sel[HALF_W-1:0]};
      end
      wide_a = {is_signed & ext_a[DATA_W-1], ext_a};
      wide_b = {is_signed & ext_b[DATA_W-1], ext_b};
   end

   assign eq = (wide_a == wide_b);

   generate
      if (BY_SUBTRACT) begin : g_sub
         logic [DATA_W+1:0] diff;
         assign diff = {wide_a[DATA_W], wide_a} - {wide_b[DATA_W], wide_b};
         assign lt = diff[DATA_W+1];
      end else begin : g_rel
         assign lt = ($signed(wide_a) < $signed(wide_b));
      end
   endgenerate

   assign gt = ~lt & ~eq;
endmodule

// File: rtl/cmp_bytematch.sv
module cmp_bytematch #(
   parameter int DATA_W = 64,
   parameter int KEY_W  = 8
) (
   input  logic [KEY_W-1:0]  key,
   input  logic [DATA_W-1:0] word,
   output logic              hit
);
   localparam int LANES = DATA_W / KEY_W;

   logic [LANES-1:0] lane_hit;

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         assign lane_hit[i] = (word[i*KEY_W +: KEY_W] == key);
      end
   endgenerate

   assign hit = |lane_hit;
endmodule

// File: rtl/cr_field_merge.sv
module cr_field_merge #(
   parameter int FIELDS = 8,
   parameter int NIB_W  = 4,
   localparam int CR_W  = FIELDS * NIB_W,
   localparam int IDX_W = $clog2(FIELDS)
) (
   input  logic [CR_W-1:0]  cr_in,
   input  logic [IDX_W-1:0] idx,
   input  logic [NIB_W-1:0] nib,
   output logic [CR_W-1:0]  cr_next
);
   generate
      for (genvar f = 0; f < FIELDS; f++) begin : g_field
         localparam int TOP = CR_W - 1 - f * NIB_W;
         assign cr_next[TOP -: NIB_W] =
            (idx == IDX_W'(f)) ? nib : cr_in[TOP -: NIB_W];
      end
   endgenerate
endmodule

// File: rtl/crcmp_unit.sv
module crcmp_unit
   import crcmp_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int HALF_W = 32,
   parameter int IMM_W  = 16,
   parameter int FIELDS = 8,
   parameter int KEY_W  = 8,
   parameter bit BY_SUBTRACT = 1'b0,
   localparam int CR_W  = FIELDS * NIB_W,
   localparam int IDX_W = $clog2(FIELDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        op_sel,
   input  logic              len_full,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   input  logic [IMM_W-1:0]  imm,
   input  logic [IDX_W-1:0]  field_idx,
   input  logic              so_in,
   input  logic [CR_W-1:0]   cr_in,
   output logic [CR_W-1:0]   cr_out
);
   generate
      if (DATA_W != 2 * HALF_W) begin : g_bad_half
         $error("DATA_W must be twice HALF_W");
      end
      if (IMM_W > HALF_W) begin : g_bad_imm
         $error("IMM_W must not exceed HALF_W");
      end
      if (DATA_W % KEY_W != 0) begin : g_bad_key
         $error("DATA_W must be a multiple of KEY_W");
      end
      if (FIELDS < 2 || (1 << IDX_W) != FIELDS) begin : g_bad_fields
         $error("FIELDS must be a power of two, at least 2");
      end
   endgenerate

   cmp_op_e op;
   logic    lt, gt, eq, hit;
   logic [NIB_W-1:0] nib;
   logic [CR_W-1:0]  cr_next;

   assign op = cmp_op_e'(op_sel);

   cmp_magnitude #(
      .DATA_W(DATA_W), .HALF_W(HALF_W), .IMM_W(IMM_W), .BY_SUBTRACT(BY_SUBTRACT)
   ) u_mag (
      .a(opnd_a), .b(opnd_b), .imm(imm),
      .is_signed(op == OP_SCMP),
      .use_imm(op == OP_UCMPI),
      .len_full(len_full),
      .lt(lt), .gt(gt), .eq(eq)
   );

   cmp_bytematch #(.DATA_W(DATA_W), .KEY_W(KEY_W)) u_byte (
      .key(opnd_a[KEY_W-1:0]), .word(opnd_b), .hit(hit)
   );

   always_comb begin
      nib = '0;
      if (op == OP_BYTEQ) begin
         nib[NIB_GT] = hit;
      end else begin
         nib[NIB_LT] = lt;
         nib[NIB_GT] = gt;
         nib[NIB_EQ] = eq;
         nib[NIB_SO] = so_in;
      end
   end

   cr_field_merge #(.FIELDS(FIELDS), .NIB_W(NIB_W)) u_merge (
      .cr_in(cr_in), .idx(field_idx), .nib(nib), .cr_next(cr_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cr_out <= '0;
      else        cr_out <= cr_next;
   end

   function automatic logic [NIB_W-1:0] pick_field(input logic [CR_W-1:0] cr,
                                                   input logic [IDX_W-1:0] idx);
      return cr[CR_W-1-NIB_W*int'(idx) -: NIB_W];
   endfunction

   function automatic logic [CR_W-1:0] field_mask(input logic [IDX_W-1:0] idx);
      logic [CR_W-1:0] m;
      m = '0;
      m[CR_W-1-NIB_W*int'(idx) -: NIB_W] = '1;
      return m;
   endfunction

   // R9: bits outside the written field follow the previous cr_in
   a_r9_keep_others: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |->
         (((cr_out ^ $past(cr_in)) & ~field_mask($past(field_idx))) == '0));

   // R3: a compare sets exactly one relation bit
   a_r3_one_relation: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(op_sel) != 2'd3) |->
         $onehot(pick_field(cr_out, $past(field_idx))[NIB_W-1:1]));

   // R3: compare nibble bit 0 follows the overflow flag
   a_r3_so_copy: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(op_sel) != 2'd3) |->
         (pick_field(cr_out, $past(field_idx))[0] == $past(so_in)));

   // R7, R8: byte search leaves only the greater-than position free to be set
   a_r8_byte_clears: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(op_sel) == 2'd3) |->
         ((pick_field(cr_out, $past(field_idx)) & 4'b1011) == 4'b0000));
endmodule

// File: tb/crcmp_unit_bench.sv
module crcmp_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  op_sel = '0;
   logic        len_full = 1'b0;
   logic [63:0] opnd_a = '0, opnd_b = '0;
   logic [15:0] imm = '0;
   logic [2:0]  field_idx = '0;
   logic        so_in = 1'b0;
   logic [31:0] cr_in = '0;
   logic [31:0] cr_out;

   int n_checks = 0;
   int n_fails = 0;
   bit finished = 0;

   typedef struct {
      logic [31:0] exp;
      string       tag;
   } item_t;
   item_t sb_q[$];

   always #5 clk = ~clk;

   crcmp_unit u_crcmp_unit (
      .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .len_full(len_full),
      .opnd_a(opnd_a), .opnd_b(opnd_b), .imm(imm), .field_idx(field_idx),
      .so_in(so_in), .cr_in(cr_in), .cr_out(cr_out)
   );

   function automatic logic [31:0] put_nib(input logic [31:0] cr, input int idx,
                                           input logic [3:0] nib);
      logic [31:0] r;
      r = cr;
      r[31-4*idx -: 4] = nib;
      return r;
   endfunction

   function automatic logic [3:0] ref_nib(input logic [1:0] op, input logic len,
                                          input logic [63:0] a, input logic [63:0] b,
                                          input logic [15:0] im, input logic so);
      logic [63:0] bb, sa, sb;
      logic [3:0]  n;
      n = 4'h0;
      if (op == 2'd3) begin
         for (int k = 0; k < 8; k++)
            if (b[8*k +: 8] == a[7:0]) n = 4'h4;
         return n;
      end
      bb = (op == 2'd2) ? {48'd0, im} : b;
      if (len) begin
         sa = a; sb = bb;
      end else if (op == 2'd0) begin
         sa = {{32{a[31]}}, a[31:0]}; sb = {{32{bb[31]}}, bb[31:0]};
      end else begin
         sa = {32'd0, a[31:0]}; sb = {32'd0, bb[31:0]};
      end
      if (sa == sb) n = 4'h2;
      else if (op == 2'd0) n = ($signed(sa) < $signed(sb)) ? 4'h8 : 4'h4;
      else n = (sa < sb) ? 4'h8 : 4'h4;
      return {n[3:1], so};
   endfunction

   task automatic drive(input logic [1:0] op, input logic len,
                        input logic [63:0] a, input logic [63:0] b,
                        input logic [15:0] im, input int idx, input logic so,
                        input logic [31:0] cr, input logic [3:0] nib, input string tag);
      item_t it;
      @(negedge clk);
      op_sel = op; len_full = len; opnd_a = a; opnd_b = b; imm = im;
      field_idx = 3'(idx); so_in = so; cr_in = cr;
      it.exp = put_nib(cr, idx, nib);
      it.tag = tag;
      sb_q.push_back(it);
   endtask

   task automatic drive_ref(input logic [1:0] op, input logic len,
                            input logic [63:0] a, input logic [63:0] b,
                            input logic [15:0] im, input int idx, input logic so,
                            input logic [31:0] cr, input string tag);
      drive(op, len, a, b, im, idx, so, cr, ref_nib(op, len, a, b, im, so), tag);
   endtask

   // monitor: compares each result one edge after it was driven (R2)
   always @(posedge clk) begin
      #2;
      if (rst_n && sb_q.size() > 0) begin
         item_t it;
         it = sb_q.pop_front();
         n_checks++;
         if (cr_out !== it.exp) begin
            n_fails++;
            $display("FAIL %s: cr_out=%h expected=%h", it.tag, cr_out, it.exp);
         end
      end
   end

   initial begin
      #2_000_000;
      if (!finished) begin
         n_fails++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      cr_in = 32'hffff_ffff;
      repeat (3) @(negedge clk);
      n_checks++;
      if (cr_out !== 32'h0) begin
         n_fails++;
         $display("FAIL R1: cr_out=%h expected=%h", cr_out, 32'h0);
      end
      rst_n = 1'b1;

      // R4 / R5 sign-extension vectors
      drive(2'd0, 1'b0, 64'hffffffffaaaaaaaa, 64'h00000000aaaaaaaa, 16'h0, 2, 1'b0,
            32'h0, 4'h2, "R4 signed len0 equal");
      drive(2'd0, 1'b1, 64'hffffffffaaaaaaaa, 64'h00000000aaaaaaaa, 16'h0, 2, 1'b0,
            32'h0, 4'h8, "R5 signed len1 less");
      drive(2'd0, 1'b1, 64'h00000000aaaaaaaa, 64'hffffffffaaaaaaaa, 16'h0, 2, 1'b0,
            32'h0, 4'h4, "R5 signed len1 greater");
      drive(2'd1, 1'b1, 64'hffffffffaaaaaaaa, 64'h00000000aaaaaaaa, 16'h0, 5, 1'b0,
            32'h1234_5678, 4'h4, "R5 unsigned len1 greater");

      // boundary 0x7fffffff vs 0x80000000
      drive(2'd0, 1'b0, 64'h7fffffff, 64'h80000000, 16'h0, 0, 1'b1,
            32'h0, 4'h5, "R4 signed len0 boundary");
      drive(2'd1, 1'b0, 64'h7fffffff, 64'h80000000, 16'h0, 0, 1'b0,
            32'h0, 4'h8, "R4 unsigned len0 boundary");
      drive(2'd0, 1'b1, 64'h7fffffff, 64'h80000000, 16'h0, 1, 1'b0,
            32'h0, 4'h8, "R5 signed len1 boundary");
      drive(2'd1, 1'b0, 64'hdead_beef_0000_0007, 64'h0000_0000_0000_0007, 16'h0, 4, 1'b1,
            32'h0, 4'h3, "R4 high half ignored");

      // R3 overflow copy
      drive(2'd1, 1'b1, 64'h5, 64'h9, 16'h0, 3, 1'b1, 32'h0, 4'h9, "R3 so copied");

      // R6 immediate: operand B ignored
      drive(2'd2, 1'b0, 64'h301fc7a7, 64'hffff_ffff_ffff_ffff, 16'd31132, 5, 1'b1,
            32'h90215393, 4'h5, "R6 imm greater");
      drive(2'd2, 1'b1, 64'h0000_0000_0000_8000, 64'h0, 16'h8000, 6, 1'b0,
            32'h0, 4'h2, "R6 imm zero-extended equal");
      drive(2'd2, 1'b0, 64'h0000_0000_0000_0001, 64'h1, 16'hffff, 7, 1'b0,
            32'h0, 4'h8, "R6 imm unsigned less");

      // R7 / R8 byte search
      drive(2'd3, 1'b0, 64'h05, 64'h0001030507090b0f, 16'h0, 1, 1'b0,
            32'hffff_ffff, 4'h4, "R7 byte hit");
      drive(2'd3, 1'b0, 64'h04, 64'h0001030507090b0f, 16'h0, 1, 1'b0,
            32'hffff_ffff, 4'h0, "R7 byte miss");
      drive(2'd3, 1'b1, 64'hffff_ffff_ffff_ff0f, 64'h0001030507090b0f, 16'h0, 6, 1'b1,
            32'h0, 4'h4, "R8 byte hit so cleared");
      drive(2'd3, 1'b0, 64'h11, 64'h2200000000000000, 16'h0, 7, 1'b1,
            32'hffff_ffff, 4'h0, "R8 byte miss so cleared");

      // R9 every field position
      for (int f = 0; f < 8; f++)
         drive(2'd0, 1'b1, 64'h42, 64'h42, 16'h0, f, 1'b0,
               32'ha5a5_5a5a ^ (32'h1111_1111 << f), 4'h2, "R9 field position");

      // R2 random coverage against the model
      for (int i = 0; i < 60; i++) begin
         logic [63:0] ra, rb;
         ra = {$urandom, $urandom};
         rb = (i % 4 == 0) ? ra : {$urandom, $urandom};
         if (i % 5 == 0) rb[31:0] = ra[31:0];
         drive_ref(2'($urandom), 1'($urandom), ra, rb, 16'($urandom),
                   int'($urandom % 8), 1'($urandom), $urandom, "R2 random");
      end

      repeat (3) @(negedge clk);
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end
endmodule